// File: doc/BRIEF.md
# Host Configuration Register File with Peripheral Chip-Select Decode

This block gives a host processor a small configuration space reached through two adjacent I/O addresses: the even address is an index register, and the odd address is a data window onto the register that the index selects. The space holds three fixed identification values. It also holds the relocatable base address of the index/data pair itself. For each of three peripheral functions it holds a 16-bit chip-select base. Finally, it holds an enable register, a sticky lock register and an interrupt-enable byte.

On every cycle the block compares the host address with each programmed peripheral base. For each function whose enable bit is set, it raises that function's chip select when the address falls in the function's two-byte window. The two-byte window follows from address bit 0 being ignored. Function 0 is the real-time clock, function 1 the keyboard controller and function 2 power management.

The base of the index/data pair is loaded directly through a load strobe, which stands in for the board-level discovery protocol. Until that load happens, the pair does not answer. Reads come back one cycle later as a valid-only response: `host_rvalid` marks the beat and there is no back-pressure, because the host cannot stall a read it has issued. Writes complete in the cycle they are presented.

Top module: `hcfg_top`

## Requirements
- R1: After reset the index register is 00h, all three chip-select bases are 0000h, and the enable, lock and interrupt-enable registers are 00h. All chip selects are low, and the index/data pair is unloaded, so it does not respond.
- R2: A pulse on `base_load` sets the pair's base to {`base_value`,0}. Address base+0 reads and writes the 8-bit index, and base+1 reads and writes the register that the index selects. A read answers on the next cycle with `host_rvalid`=1 and `host_rdata`. Before the first load, accesses have no effect and produce no response.
- R3: Index 20h reads 00h, index 21h reads 01h and index 22h reads 00h. Writes to these indexes change nothing.
- R4: Index 26h holds pair-base bits 15:8. Index 27h holds bits 7:1, and its bit 0 reads 0. Writes to these indexes take effect at once and move the pair, but only while lock bit 0 is 0. `base_load` applies regardless of the lock.
- R5: Indexes 50h/51h (high/low) hold the function 0 chip-select base, 52h/53h the function 1 base, and 54h/55h the function 2 base. Each low byte's bit 0 reads 0. A function's pair accepts writes only while lock bit f+1 is 0.
- R6: Index 56h is the enable register. Bits 2:0 enable functions 0..2, and bits 7:3 read 0.
- R7: Index 57h is the lock register. Writing 1 to bit 0 (pair base) or to bits 1..3 (functions 0..2) sets that bit. Writing 0 does not clear it; only reset does. Bits 7:4 read 0.
- R8: Index 58h is an interrupt-enable byte that reads back all 8 bits as written.
- R9: Any other index reads FFh, and a write to it changes nothing.
- R10: `cs_out[f]` is 1 in the same cycle exactly when enable bit f is 1 and `host_addr[15:1]` equals bits 15:1 of function f's base.
- R11: When `host_rd` and `host_wr` address the data port in the same cycle, the read returns the value from before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_load | input | 1 | Load strobe for the index/data pair base |
| base_value | input | 15 | Pair base bits 15:1 |
| host_addr | input | 16 | Host I/O address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response beat, one cycle after an accepted read |
| cs_out | output | 3 | Chip selects: bit 0 clock, bit 1 keyboard, bit 2 power |

## Verification
The bench builds the block with its default package constants: three functions, 16-bit addresses and 8-bit data. With these values it programs two functions' windows only two bytes apart and sweeps the host address across both, which exercises the bit-0 masking at each window edge. The bench moves the pair twice through its own registers and then locks it. This shows that lock stickiness, a write landing at the moved address, and a direct load over a locked base all match the reference model on every cycle.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;
  parameter int AW    = 16;
  parameter int DW    = 8;
  parameter int NF    = 3;
  localparam int LOCKW = NF + 1;

  typedef logic [DW-1:0] idx_t;

  localparam idx_t IX_ID      = 8'h20;
  localparam idx_t IX_TYPE    = 8'h21;
  localparam idx_t IX_REV     = 8'h22;
  localparam idx_t IX_BASE_HI = 8'h26;
  localparam idx_t IX_BASE_LO = 8'h27;
  localparam idx_t IX_CS0     = 8'h50;
  localparam idx_t IX_FEN     = IX_CS0 + idx_t'(2 * NF);
  localparam idx_t IX_FLOCK   = IX_FEN + 8'd1;
  localparam idx_t IX_IRQEN   = IX_FEN + 8'd2;

  localparam logic [DW-1:0] VAL_ID   = 8'h00;
  localparam logic [DW-1:0] VAL_TYPE = 8'h01;
  localparam logic [DW-1:0] VAL_REV  = 8'h00;
  localparam logic [DW-1:0] VAL_NONE = 8'hFF;
endpackage

// File: rtl/hcfg_regs.sv
module hcfg_regs
  import hcfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     base_load,
  input  logic [AW-1:1]            base_value,
  input  logic                     wr_en,
  input  idx_t                     idx,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic [AW-1:1]            pair_base,
  output logic                     pair_valid,
  output logic [NF-1:0][AW-1:1]    fbase,
  output logic [NF-1:0]            fen
);
  logic [AW-1:1]    base_q;
  logic             valid_q;
  logic [AW-1:1]    fb_q [NF];
  logic [NF-1:0]    fen_q;
  logic [LOCKW-1:0] lock_q;
  logic [DW-1:0]    irq_q;

  // pair base: direct load wins over a host write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      valid_q <= 1'b0;
    end else if (base_load) begin
      base_q  <= base_value;
      valid_q <= 1'b1;
    end else if (wr_en && !lock_q[0]) begin
      if (idx == IX_BASE_HI) base_q[AW-1:DW] <= wdata;
      if (idx == IX_BASE_LO) base_q[DW-1:1]  <= wdata[DW-1:1];
    end
  end

  // per-function chip-select base, each guarded by its own lock bit
  for (genvar f = 0; f < NF; f++) begin : g_fn
    localparam idx_t HI_IX = IX_CS0 + idx_t'(2 * f);
    localparam idx_t LO_IX = HI_IX + 8'd1;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fb_q[f] <= '0;
      end else if (wr_en && !lock_q[f+1]) begin
        if (idx == HI_IX) fb_q[f][AW-1:DW] <= wdata;
        if (idx == LO_IX) fb_q[f][DW-1:1]  <= wdata[DW-1:1];
      end
    end
    assign fbase[f] = fb_q[f];

    a_r5_locked_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[f+1] |=> $stable(fb_q[f]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fen_q  <= '0;
      lock_q <= '0;
      irq_q  <= '0;
    end else if (wr_en) begin
      if (idx == IX_FEN)   fen_q  <= wdata[NF-1:0];
      if (idx == IX_FLOCK) lock_q <= lock_q | wdata[LOCKW-1:0];
      if (idx == IX_IRQEN) irq_q  <= wdata;
    end
  end

  always_comb begin
    rdata = VAL_NONE;
    if (idx == IX_ID)      rdata = VAL_ID;
    if (idx == IX_TYPE)    rdata = VAL_TYPE;
    if (idx == IX_REV)     rdata = VAL_REV;
    if (idx == IX_BASE_HI) rdata = base_q[AW-1:DW];
    if (idx == IX_BASE_LO) rdata = {base_q[DW-1:1], 1'b0};
    for (int f = 0; f < NF; f++) begin
      if (idx == IX_CS0 + idx_t'(2 * f))        rdata = fb_q[f][AW-1:DW];
      if (idx == IX_CS0 + idx_t'(2 * f) + 8'd1) rdata = {fb_q[f][DW-1:1], 1'b0};
    end
    if (idx == IX_FEN)     rdata = DW'(fen_q);
    if (idx == IX_FLOCK)   rdata = DW'(lock_q);
    if (idx == IX_IRQEN)   rdata = irq_q;
  end

  assign pair_base  = base_q;
  assign pair_valid = valid_q;
  assign fen        = fen_q;

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  a_r4_locked_pair_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q[0] && !base_load) |=> $stable(base_q));
endmodule

// File: rtl/hcfg_port.sv
module hcfg_port
  import hcfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  host_addr,
  input  logic           host_rd,
  input  logic           host_wr,
  input  logic [DW-1:0]  host_wdata,
  input  logic [AW-1:1]  pair_base,
  input  logic           pair_valid,
  input  logic [DW-1:0]  reg_rdata,
  output logic           reg_wr,
  output idx_t           idx,
  output logic [DW-1:0]  host_rdata,
  output logic           host_rvalid
);
  logic          hit;
  idx_t          idx_q;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  assign hit    = pair_valid && (host_addr[AW-1:1] == pair_base);
  assign reg_wr = hit && host_wr && host_addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (hit && host_wr && !host_addr[0]) idx_q <= host_wdata;
      rvalid_q <= hit && host_rd;
      if (hit && host_rd) rdata_q <= host_addr[0] ? reg_rdata : idx_q;
    end
  end

  assign idx         = idx_q;
  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;

  a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && hit) |=> host_rvalid);

  a_r2_silent_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |=> !host_rvalid);
endmodule

// File: rtl/hcfg_csdec.sv
module hcfg_csdec
  import hcfg_pkg::*;
(
  input  logic [AW-1:0]         host_addr,
  input  logic [NF-1:0][AW-1:1] fbase,
  input  logic [NF-1:0]         fen,
  output logic [NF-1:0]         cs
);
  for (genvar f = 0; f < NF; f++) begin : g_cmp
    assign cs[f] = fen[f] && (host_addr[AW-1:1] == fbase[f]);
  end
endmodule

// File: rtl/hcfg_top.sv
module hcfg_top
  import hcfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           base_load,
  input  logic [AW-1:1]  base_value,
  input  logic [AW-1:0]  host_addr,
  input  logic           host_rd,
  input  logic           host_wr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_rvalid,
  output logic [NF-1:0]  cs_out
);
  logic                  reg_wr;
  idx_t                  idx;
  logic [DW-1:0]         reg_rdata;
  logic [AW-1:1]         pair_base;
  logic                  pair_valid;
  logic [NF-1:0][AW-1:1] fbase;
  logic [NF-1:0]         fen;

  hcfg_port u_port (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .pair_base(pair_base), .pair_valid(pair_valid),
    .reg_rdata(reg_rdata), .reg_wr(reg_wr), .idx(idx),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  hcfg_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .base_load(base_load), .base_value(base_value),
    .wr_en(reg_wr), .idx(idx), .wdata(host_wdata), .rdata(reg_rdata),
    .pair_base(pair_base), .pair_valid(pair_valid),
    .fbase(fbase), .fen(fen)
  );

  hcfg_csdec u_dec (
    .host_addr(host_addr), .fbase(fbase), .fen(fen), .cs(cs_out)
  );

  a_r10_cs_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_out & ~fen) == '0);
endmodule

// File: tb/tb_hcfg_top.sv
module tb_hcfg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_load = 1'b0;
  logic [15:1] base_value = '0;
  logic [15:0] host_addr = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [2:0]  cs_out;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_idx, m_base, m_valid, m_en, m_lock, m_irq;
  int m_fb [3];
  int cur;

  always #4 clk = ~clk;

  hcfg_top dut (
    .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_value(base_value),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .cs_out(cs_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int mread(input int i);
    if (i == 'h20) return 'h00;
    if (i == 'h21) return 'h01;
    if (i == 'h22) return 'h00;
    if (i == 'h26) return (m_base >> 8) & 'hFF;
    if (i == 'h27) return m_base & 'hFE;
    if (i >= 'h50 && i <= 'h55)
      return ((i - 'h50) % 2 == 0) ? (m_fb[(i - 'h50) / 2] >> 8) & 'hFF
                                   : m_fb[(i - 'h50) / 2] & 'hFE;
    if (i == 'h56) return m_en;
    if (i == 'h57) return m_lock;
    if (i == 'h58) return m_irq;
    return 'hFF;
  endfunction

  task automatic mwrite(input int i, input int d);
    int f;
    if ((i == 'h26) && !m_lock[0]) m_base = (d << 8) | (m_base & 'hFF);
    if ((i == 'h27) && !m_lock[0]) m_base = (m_base & 'hFF00) | (d & 'hFE);
    if (i >= 'h50 && i <= 'h55) begin
      f = (i - 'h50) / 2;
      if (!m_lock[f+1]) begin
        if ((i - 'h50) % 2 == 0) m_fb[f] = (d << 8) | (m_fb[f] & 'hFF);
        else                     m_fb[f] = (m_fb[f] & 'hFF00) | (d & 'hFE);
      end
    end
    if (i == 'h56) m_en = d & 7;
    if (i == 'h57) m_lock = m_lock | (d & 'hF);
    if (i == 'h58) m_irq = d;
  endtask

  function automatic string tag_of(input int a, input int i, input int both);
    if (both) return "R11";
    if ((a & 1) == 0) return "R2";
    if (i >= 'h20 && i <= 'h22) return "R3";
    if (i == 'h26 || i == 'h27) return "R4";
    if (i >= 'h50 && i <= 'h55) return "R5";
    if (i == 'h56) return "R6";
    if (i == 'h57) return "R7";
    if (i == 'h58) return "R8";
    return "R9";
  endfunction

  // one host cycle, model updated, outputs compared after the edge
  task automatic cyc(input int a, input int rd, input int wr, input int wd,
                     input int ld = 0, input int ldv = 0);
    int hit, erv, erd, ecs;
    string t;
    host_addr = 16'(a); host_rd = rd[0]; host_wr = wr[0]; host_wdata = 8'(wd);
    base_load = ld[0]; base_value = 15'(ldv >> 1);
    hit = m_valid && ((a >> 1) == (m_base >> 1));
    erv = hit && rd;
    erd = 0;
    t = tag_of(a, m_idx, rd && wr);
    if (erv) erd = (a & 1) ? mread(m_idx) : m_idx;
    if (hit && wr) begin
      if (a & 1) mwrite(m_idx, wd);
      else m_idx = wd & 'hFF;
    end
    if (ld) begin m_base = ldv & 'hFFFE; m_valid = 1; end
    @(posedge clk); #2;
    check("R2 rvalid", int'(host_rvalid), erv);
    if (erv) check(t, int'(host_rdata), erd);
    ecs = 0;
    for (int f = 0; f < 3; f++)
      if (m_en[f] && ((a >> 1) == (m_fb[f] >> 1))) ecs |= (1 << f);
    check("R10 cs_out", int'(cs_out), ecs);
    host_rd = 0; host_wr = 0; base_load = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; host_rd = 0; host_wr = 0; base_load = 0; host_addr = '0;
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1;
    m_idx = 0; m_base = 0; m_valid = 0; m_en = 0; m_lock = 0; m_irq = 0;
    for (int f = 0; f < 3; f++) m_fb[f] = 0;
    check("R1 cs_out after reset", int'(cs_out), 0);
    check("R1 rvalid after reset", int'(host_rvalid), 0);
  endtask

  task automatic wr_reg(input int i, input int d);
    cyc(cur, 0, 1, i);
    cyc(cur + 1, 0, 1, d);
  endtask

  task automatic rd_reg(input int i);
    cyc(cur, 0, 1, i);
    cyc(cur + 1, 1, 0, 0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1/R2: unloaded pair ignores accesses
    cyc('h0000, 1, 1, 'h55);
    cyc('h0001, 1, 1, 'h66);
    cyc('h002E, 1, 0, 0);
    // R2: load pair base, read reset index
    cyc('h0000, 0, 0, 0, 1, 'h002F);
    cur = 'h002E;
    cyc(cur, 1, 0, 0);
    // R3: identification values and ignored writes
    rd_reg('h20); rd_reg('h21); rd_reg('h22);
    wr_reg('h21, 'h5A); rd_reg('h21);
    wr_reg('h20, 'h33); rd_reg('h20);
    // R1: other registers start at zero
    rd_reg('h50); rd_reg('h56); rd_reg('h57); rd_reg('h58);
    // R5: chip-select bases, low bit forced to 0
    wr_reg('h50, 'h00); wr_reg('h51, 'h71); rd_reg('h51);
    wr_reg('h52, 'h00); wr_reg('h53, 'h60);
    wr_reg('h54, 'h00); wr_reg('h55, 'h62); rd_reg('h55); rd_reg('h54);
    // R10: decode gated by enable
    cyc('h0070, 0, 0, 0);
    // R6: enable register, upper bits read 0
    wr_reg('h56, 'hFD); rd_reg('h56);
    for (int a = 'h5E; a <= 'h73; a++) cyc(a, 0, 0, 0);
    wr_reg('h56, 'h07);
    for (int a = 'h5E; a <= 'h73; a++) cyc(a, 0, 0, 0);
    cyc('h1070, 0, 0, 0);
    // R9: unimplemented indexes
    rd_reg('h10); rd_reg('h59); wr_reg('h59, 'h12); rd_reg('h59); rd_reg('hFF);
    // R8: interrupt enable byte
    wr_reg('h58, 'hA5); rd_reg('h58);
    // R11: simultaneous read and write
    cyc(cur, 0, 1, 'h58);
    cyc(cur + 1, 1, 1, 'h3C);
    cyc(cur + 1, 1, 0, 0);
    // R7/R5: lock function 0, sticky against clearing
    wr_reg('h57, 'hF2); rd_reg('h57);
    wr_reg('h50, 'h12); rd_reg('h50); wr_reg('h51, 'h20); rd_reg('h51);
    cyc('h0070, 0, 0, 0);
    wr_reg('h57, 'h00); rd_reg('h57);
    wr_reg('h52, 'h01); rd_reg('h52);
    cyc('h0160, 0, 0, 0);
    // R4: relocate the pair through its own registers
    wr_reg('h26, 'h01);
    cur = 'h012E;
    cyc(cur, 1, 0, 0);
    cyc(cur, 0, 1, 'h27);
    cyc(cur + 1, 0, 1, 'h41);
    cyc('h002E, 1, 0, 0);
    cur = 'h0140;
    rd_reg('h27); rd_reg('h26);
    // R4/R7: lock the pair base
    wr_reg('h57, 'h01); rd_reg('h57);
    wr_reg('h26, 'h77); rd_reg('h26);
    wr_reg('h27, 'h10); rd_reg('h27);
    // R2: direct load still applies while locked
    cyc('h0000, 0, 0, 0, 1, 'h00A0);
    cur = 'h00A0;
    rd_reg('h26); rd_reg('h27);
    // R1: reset clears everything, pair silent again
    do_reset();
    cyc('h00A0, 1, 0, 0);
    cyc('h0000, 0, 0, 0);
    cyc('h0000, 0, 0, 0, 1, 'h0300);
    cur = 'h0300;
    rd_reg('h57); rd_reg('h56); rd_reg('h58);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule